// File: doc/BRIEF.md
# Digit-Serial GF(2^191) Multiplier with Squaring

This block multiplies two elements of the binary field GF(2^191) and reduces the product modulo the fixed trinomial x^191 + x^9 + 1. The first operand is held in full. The second is consumed one digit of `DIGIT_W` bits per clock, most significant digit first. Each digit step shifts the running value left by one digit and XORs in a carry-free partial product built from AND gates. The bits that overflow past position 190 are folded back straight away, so the working value never grows more than one digit beyond the field width.

Squaring has its own single-pass path. The operand's bits are spread out with zeros between them, and the 381-bit result is folded back with the same trinomial. The result is registered one clock after the request.

A client presents both operands, selects the operation and raises `start` for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse and reads `product`, which holds its value until the next operation completes.

Top module: `gfmul191`

## Requirements
- R1: With operands below degree 191, a multiply returns a·b mod (x^191 + x^9 + 1), where bit i of a port is the coefficient of x^i.
- R2: A multiply accepted on a clock edge raises `busy` after that edge and raises `done` exactly ceil(191/DIGIT_W)+1 edges later, counting the accepting edge as edge 0.
- R3: With `opSquare` = 1, an accepted request yields a² mod (x^191 + x^9 + 1) with `done` high after the very next edge, and `busy` stays low throughout.
- R4: `done` is high for one cycle per completed operation, and `busy` falls on the same edge that raises `done`.
- R5: A `start` given while `busy` is high is ignored: new operand values and a different operation select change neither the result nor the completion time of the running multiply.
- R6: While `rstN` is low, `busy`, `done` and `product` are all 0.
- R7: Corner operands give the field identities: a·0 = 0, a·1 = a, and x^i·x^190 and (x^i)² reduce with the trinomial's folds of bit k ≥ 191 into positions k−191 and k−182.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request, accepted when `busy` is low |
| opSquare | input | 1 | 1 selects squaring of `opA`, 0 selects multiplication |
| opA | input | 191 | First operand, used at full precision |
| opB | input | 191 | Second operand, consumed digit by digit |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse when `product` holds a new result |
| product | output | 191 | Registered result |

## Verification
The assertions assume that `start` is a clean synchronous request and that operands are already reduced, meaning bits above 190 do not exist at the ports. They also assume that a multiply always runs to completion, because the block has no abort. The stimulus drives every input on the falling edge and holds `start` high for exactly one cycle per request. The only exceptions are the deliberate mid-run pulses, which carry altered operands and the opposite operation select. The sweeps use single-term operands x^i for every i so that each fold position is reached, and add random full-width operands. Every result is compared with a bit-serial shift-and-XOR model.

// File: rtl/gfmul_pkg.sv
package gfmul_pkg;

  localparam int FIELD_M = 191;
  localparam int POLY_TAP = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } ctrlState_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finishMul;
    logic finishSq;
  } dpStrobes_t;

  // Interleave zeros: coefficient i moves to position 2i.
  function automatic logic [2*FIELD_M-2:0] spreadBits(input logic [FIELD_M-1:0] a);
    logic [2*FIELD_M-2:0] e;
    e = '0;
    for (int i = 0; i < FIELD_M; i++) begin
      e[2*i] = a[i];
    end
    return e;
  endfunction

  // Fold every term of degree >= FIELD_M back, from the top down.
  function automatic logic [FIELD_M-1:0] foldWide(input logic [2*FIELD_M-2:0] wide);
    logic [2*FIELD_M-2:0] v;
    v = wide;
    for (int k = 2*FIELD_M-2; k >= FIELD_M; k--) begin
      if (v[k]) begin
        v[k] = 1'b0;
        v[k-FIELD_M] = ~v[k-FIELD_M];
        v[k-FIELD_M+POLY_TAP] = ~v[k-FIELD_M+POLY_TAP];
      end
    end
    return v[FIELD_M-1:0];
  endfunction

endpackage

// File: rtl/gfmul_square.sv
module gfmul_square
  import gfmul_pkg::*;
(
  input  logic [FIELD_M-1:0] sqIn,
  output logic [FIELD_M-1:0] sqOut
);

  logic [2*FIELD_M-2:0] expanded;

  always_comb begin
    expanded = spreadBits(sqIn);
    sqOut    = foldWide(expanded);
  end

endmodule

// File: rtl/gfmul_datapath.sv
module gfmul_datapath
  import gfmul_pkg::*;
#(
  parameter int DIGIT_W = 8,
  parameter int NUM_DIGITS = (FIELD_M + DIGIT_W - 1) / DIGIT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic [FIELD_M-1:0] aIn,
  input  logic [FIELD_M-1:0] bIn,
  input  logic [FIELD_M-1:0] sqIn,
  output logic [FIELD_M-1:0] resultOut
);

  localparam int PAD_W = NUM_DIGITS * DIGIT_W;
  localparam int EXT_W = FIELD_M + DIGIT_W;

  logic [FIELD_M-1:0] aReg;
  logic [PAD_W-1:0]   bReg;
  logic [FIELD_M-1:0] acc;
  logic [FIELD_M-1:0] resReg;

  logic [DIGIT_W-1:0] digit;
  logic [EXT_W-1:0]   ppTerm [DIGIT_W];
  logic [EXT_W-1:0]   ppSum;
  logic [EXT_W-1:0]   stepSum;
  logic [DIGIT_W-1:0] overflow;
  logic [FIELD_M-1:0] overflowExt;
  logic [FIELD_M-1:0] accNext;

  assign digit = bReg[PAD_W-1 -: DIGIT_W];

  // One AND row per digit bit, each offset by its bit weight.
  for (genvar j = 0; j < DIGIT_W; j++) begin : g_pp
    assign ppTerm[j] = digit[j] ? ({{DIGIT_W{1'b0}}, aReg} << j) : '0;
  end

  always_comb begin
    ppSum = '0;
    for (int j = 0; j < DIGIT_W; j++) begin
      ppSum = ppSum ^ ppTerm[j];
    end
  end

  // Align the running value by one digit, add, then fold the spill once.
  always_comb begin
    stepSum     = {acc, {DIGIT_W{1'b0}}} ^ ppSum;
    overflow    = stepSum[EXT_W-1:FIELD_M];
    overflowExt = {{(FIELD_M-DIGIT_W){1'b0}}, overflow};
    accNext     = stepSum[FIELD_M-1:0] ^ overflowExt ^ (overflowExt << POLY_TAP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg   <= '0;
      bReg   <= '0;
      acc    <= '0;
      resReg <= '0;
    end else begin
      if (strobes.load) begin
        aReg <= aIn;
        bReg <= {{(PAD_W-FIELD_M){1'b0}}, bIn};
        acc  <= '0;
      end else if (strobes.step) begin
        bReg <= bReg << DIGIT_W;
        acc  <= accNext;
      end
      if (strobes.finishMul) begin
        resReg <= acc;
      end else if (strobes.finishSq) begin
        resReg <= sqIn;
      end
    end
  end

  assign resultOut = resReg;

  // R1: a fresh multiply starts from an empty accumulator
  p_acc_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (acc == '0));

  // R5: operand register is untouched while digits are being consumed
  p_a_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> $stable(aReg));

endmodule

// File: rtl/gfmul_ctrl.sv
module gfmul_ctrl
  import gfmul_pkg::*;
#(
  parameter int NUM_DIGITS = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opSquare,
  output dpStrobes_t strobes,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(NUM_DIGITS + 1);
  localparam logic [CNT_W-1:0] LAST_DIGIT = CNT_W'(NUM_DIGITS - 1);

  ctrlState_e state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic doneReg;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (opSquare) begin
            strobes.finishSq = 1'b1;
          end else begin
            strobes.load = 1'b1;
            stateNext    = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strobes.step = 1'b1;
        if (cnt == LAST_DIGIT) stateNext = ST_FIN;
      end
      ST_FIN: begin
        strobes.finishMul = 1'b1;
        stateNext         = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= strobes.finishMul | strobes.finishSq;
      if (strobes.load) cnt <= '0;
      else if (strobes.step) cnt <= cnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

  // R2: digit counter never runs past the last digit
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (cnt < CNT_W'(NUM_DIGITS)));

  // R2: an accepted multiply goes busy without an early done
  p_mul_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !opSquare) |=> (busy && !done));

  // R3: square completes after one edge without going busy
  p_sq_fast_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opSquare) |=> (done && !busy));

  // R4: busy drops exactly when done rises
  p_busy_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R4: done is never seen during a run
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5: a request while busy does not abort the run
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (state == ST_RUN)) |=> busy);

endmodule

// File: rtl/gfmul191.sv
module gfmul191
  import gfmul_pkg::*;
#(
  parameter int DIGIT_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         opSquare,
  input  logic [190:0] opA,
  input  logic [190:0] opB,
  output logic         busy,
  output logic         done,
  output logic [190:0] product
);

  localparam int NUM_DIGITS = (FIELD_M + DIGIT_W - 1) / DIGIT_W;

  dpStrobes_t strobes;
  logic [FIELD_M-1:0] sqVal;

  gfmul_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opSquare (opSquare),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  gfmul_square u_sq (
    .sqIn  (opA),
    .sqOut (sqVal)
  );

  gfmul_datapath #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .aIn       (opA),
    .bIn       (opB),
    .sqIn      (sqVal),
    .resultOut (product)
  );

  // R6: while reset is held, the outputs sit at zero
  always_comb begin
    if (rstN === 1'b0) begin
      p_reset_quiet_r6: assert (!busy && !done && (product == '0));
    end
  end

endmodule

// File: tb/sim_gfmul191.sv
module sim_gfmul191;

  localparam int W  = 8;
  localparam int ND = (191 + W - 1) / W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         opSquare = 1'b0;
  logic [190:0] opA = '0;
  logic [190:0] opB = '0;
  logic         busy;
  logic         done;
  logic [190:0] product;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  gfmul191 #(.DIGIT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSquare(opSquare),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .product(product)
  );

  always #10 clk = ~clk;

  // Bit-serial model: Horner scheme over b, reducing by x^191 = x^9 + 1.
  function automatic logic [190:0] refMul(input logic [190:0] a, input logic [190:0] b);
    logic [190:0] c;
    logic hiBit;
    c = '0;
    for (int i = 190; i >= 0; i--) begin
      hiBit = c[190];
      c = c << 1;
      if (hiBit) begin
        c[0] = ~c[0];
        c[9] = ~c[9];
      end
      if (b[i]) c = c ^ a;
    end
    return c;
  endfunction

  function automatic logic [190:0] randOp();
    logic [191:0] r;
    r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    return r[190:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [190:0] act, input logic [190:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Multiply; when midPulse > 0 a conflicting request is injected mid-run (R5).
  task automatic doMul(input logic [190:0] a, input logic [190:0] b, input int midPulse, input string tag);
    logic [190:0] expv;
    int lat;
    expv = refMul(a, b);
    @(negedge clk);
    opA = a; opB = b; opSquare = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    check(busy === 1'b1 && done === 1'b0, "R2 busy after accept", {190'd0, busy}, 191'd1);
    while (done !== 1'b1 && lat < 200) begin
      if (midPulse > 0 && lat == midPulse) begin
        opA = ~a; opB = a ^ b; opSquare = 1'b1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == ND + 1, {tag, " R2 latency"}, 191'(lat), 191'(ND + 1));
    check(product === expv, {tag, " R1 product"}, product, expv);
    check(busy === 1'b0, {tag, " R4 busy low with done"}, {190'd0, busy}, 191'd0);
    @(negedge clk);
    check(done === 1'b0, {tag, " R4 done single cycle"}, {190'd0, done}, 191'd0);
  endtask

  task automatic doSq(input logic [190:0] a, input string tag);
    logic [190:0] expv;
    expv = refMul(a, a);
    @(negedge clk);
    opA = a; opSquare = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; opSquare = 1'b0;
    check(done === 1'b1 && busy === 1'b0, {tag, " R3 one-cycle done"}, {189'd0, done, busy}, 191'd2);
    check(product === expv, {tag, " R3 square"}, product, expv);
    @(negedge clk);
    check(done === 1'b0, {tag, " R4 done single cycle"}, {190'd0, done}, 191'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finishRun();
      end
    end
  end

  initial begin
    logic [190:0] one;
    logic [190:0] top;
    one = 191'd1;
    top = one << 190;
    repeat (3) @(negedge clk);
    // R6 reset values
    check(busy === 1'b0 && done === 1'b0, "R6 control outputs in reset", {189'd0, busy, done}, 191'd0);
    check(product === '0, "R6 product in reset", product, 191'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R7 identities and corner operands
    doMul('0, randOp(), 0, "R7 zero times b");
    doMul(randOp(), '0, 0, "R7 a times zero");
    doMul(one, one, 0, "R7 one times one");
    begin
      logic [190:0] r;
      r = randOp();
      doMul(r, one, 0, "R7 a times one");
      check(product === r, "R7 identity a*1", product, r);
    end
    doMul(top, top, 0, "R7 x^190 squared via multiply");
    doSq(top, "R7 x^190 squared");
    doSq('0, "R7 zero squared");
    doSq(one, "R7 one squared");

    // R7 sweep of every single-term operand against the top term
    for (int i = 0; i < 191; i++) begin
      doMul(one << i, top, 0, "R7 sweep x^i*x^190");
      doSq(one << i, "R7 sweep (x^i)^2");
    end

    // R1 / R3 random full-width operands
    for (int n = 0; n < 60; n++) begin
      doMul(randOp(), randOp(), 0, "R1 random");
    end
    for (int n = 0; n < 30; n++) begin
      doSq(randOp(), "R3 random");
    end

    // R5 conflicting requests while busy, at several points in the run
    for (int p = 1; p <= ND; p += 5) begin
      doMul(randOp(), randOp(), p, "R5 ignored start");
    end
    doMul(top, randOp(), ND, "R5 ignored start at final step");

    finishRun();
  end

endmodule